// File: doc/BRIEF.md
# I/O Request Validator and Error Classifier

This block sits between the header parser of a serial-fabric logical layer and a memory-mapped bus master. Each parsed I/O request header is presented for one cycle with a valid strobe. The block decides whether the request is forwarded to the master, rejected as an unsupported transaction, or rejected as an illegal transaction decode. The verdict, together with a flag saying whether an ERROR-status response has to be built, appears one clock later.

Unsupported types are found by looking up the request class in a capability-enable vector. Supported types then go through a fixed set of decode rules: priority, payload presence, reserved size codes, address-window hits, read lane coverage and payload length. Errors set sticky detect bits that software clears. The first failing header after a clear is held in capture registers. A separate path turns a read-error indication on the final beat of a forwarded read into a request for an ERROR response.

The header input has no back-pressure. The block takes one header in every cycle that `hdr_valid` is high and never stalls. The verdict is a valid-only pulse with no ready, so the consumer must take it in the cycle it appears.

Top module: `rv_request_checker`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `hdr_valid` high. `res_code`, `res_rsp_err`, the sticky bits and the capture registers reflect that header in the same cycle. The codes are 0 forward, 1 unsupported and 2 illegal.
- R2: Class decode uses (ftype, ttype). (2,4) is read (class 0). (5,4) is write (class 1). (5,5) is write-with-response (class 2). ftype 6 is streaming write (class 3). (2,12..15) is atomic-2 (class 4). (5,12..14) is atomic-5 (class 5). Anything else is always unsupported. Class k is supported only when `op_en[k]` is 1. The unsupported test comes first, and an unsupported request is never reported as illegal.
- R3: A supported request with priority 3 is illegal.
- R4: A write, write-with-response or streaming write with `hdr_paylen` 0 is illegal. A read with `hdr_paylen` not equal to 0 is illegal.
- R5: For a write or write-with-response, the following size/wdptr combinations are reserved and illegal: 13/0, 14/0, 14/1 and 15/0.
- R6: A read, write, write-with-response or streaming write is illegal unless some window i has `win_en[i]` set and satisfies (addr & mask_i) == (base_i & mask_i).
- R7: A read is illegal unless its implied length is a multiple of BEAT_BYTES (default 8). The implied length by size code is: 0..3 give 1; 4 gives 2; 5 gives 3; 6 gives 2; 7 gives 5; 8 gives 4; 9 gives 6; 10 gives 7. Codes 11, 12, 13, 14 and 15 give 8, 32, 96, 160 and 224 when wdptr is 0, and 16, 64, 128, 192 and 256 when wdptr is 1.
- R8: A write or write-with-response whose `hdr_paylen` differs from the implied length given in R7 is illegal.
- R9: `res_rsp_err` is 1 only for an illegal read, write-with-response or atomic-5. It is never 1 for a forward or unsupported verdict.
- R10: `rd_err_rsp` is high in the cycle after a cycle where `rd_done` and `rd_err` are both high, and low otherwise.
- R11: `err_unsup` or `err_illegal` sets on the matching verdict and stays set until `err_clr` is pulsed. If an error arrives in the same cycle as `err_clr`, the error bit is set.
- R12: The capture registers (ftype, ttype, source ID, address, priority) load only on an error that arrives while neither sticky bit is set, or in the same cycle as `err_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_ftype | input | 4 | Format type |
| hdr_ttype | input | 4 | Transaction type |
| hdr_prio | input | 2 | Priority |
| hdr_size | input | 4 | Read or write size code |
| hdr_wdptr | input | 1 | Word pointer bit |
| hdr_srcid | input | SRCID_W | Source ID |
| hdr_addr | input | ADDR_W | Request address |
| hdr_paylen | input | 9 | Payload byte count |
| op_en | input | 6 | Capability enable per class |
| win_en | input | NWIN | Window enables |
| win_base | input | NWIN*ADDR_W | Window bases, window i at bits i*ADDR_W |
| win_mask | input | NWIN*ADDR_W | Window compare masks |
| err_clr | input | 1 | Clear sticky error bits |
| rd_done | input | 1 | Final beat of a forwarded read |
| rd_err | input | 1 | Read error from the bus side |
| res_valid | output | 1 | Verdict valid |
| res_code | output | 2 | Verdict code |
| res_rsp_err | output | 1 | ERROR response required |
| rd_err_rsp | output | 1 | ERROR response for a failed read |
| err_unsup | output | 1 | Sticky unsupported detect |
| err_illegal | output | 1 | Sticky illegal-decode detect |
| cap_ftype | output | 4 | Captured ftype |
| cap_ttype | output | 4 | Captured ttype |
| cap_srcid | output | SRCID_W | Captured source ID |
| cap_addr | output | ADDR_W | Captured address |
| cap_prio | output | 2 | Captured priority |

## Verification
The hardest case to reach from the ports is a request that breaks several rules at once. An example is a read with priority 3 whose class has been disabled, where only the unsupported verdict may show. The stimulus gets there by clearing one capability bit on the fly and sending a header that would also fail decode.

Capture preservation is also hard to reach: a second and third error must leave the captured fields untouched. This is reached by sending errors back to back without a clear, then clearing and confirming that the next error does load.

// File: rtl/rv_pkg.sv
package rv_pkg;
  typedef enum logic [2:0] {
    OP_NREAD    = 3'd0,
    OP_NWRITE   = 3'd1,
    OP_NWRITE_R = 3'd2,
    OP_SWRITE   = 3'd3,
    OP_ATOM2    = 3'd4,
    OP_ATOM5    = 3'd5,
    OP_OTHER    = 3'd6
  } op_class_e;

  typedef enum logic [1:0] {
    VERDICT_FWD   = 2'd0,
    VERDICT_UNSUP = 2'd1,
    VERDICT_ILL   = 2'd2
  } verdict_e;

  localparam int unsigned NUM_CLASSES  = 6;
  localparam logic [1:0]  PRIO_ILLEGAL = 2'd3;

  // Implied byte count of a size code; 0 marks a reserved combination.
  function automatic logic [8:0] size_to_bytes(input logic [3:0] code,
                                               input logic wdptr,
                                               input logic is_wr);
    logic [8:0] n;
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3: n = 9'd1;
      4'd4:  n = 9'd2;
      4'd5:  n = 9'd3;
      4'd6:  n = 9'd2;
      4'd7:  n = 9'd5;
      4'd8:  n = 9'd4;
      4'd9:  n = 9'd6;
      4'd10: n = 9'd7;
      4'd11: n = wdptr ? 9'd16 : 9'd8;
      4'd12: n = wdptr ? 9'd64 : 9'd32;
      4'd13: n = wdptr ? 9'd128 : (is_wr ? 9'd0 : 9'd96);
      4'd14: n = is_wr ? 9'd0 : (wdptr ? 9'd192 : 9'd160);
      default: n = wdptr ? 9'd256 : (is_wr ? 9'd0 : 9'd224);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/rv_hdr_decode.sv
module rv_hdr_decode
  import rv_pkg::*;
(
  input  logic [3:0] ftype,
  input  logic [3:0] ttype,
  input  logic [3:0] size_code,
  input  logic       wdptr,
  output op_class_e  op,
  output logic [8:0] size_bytes,
  output logic       size_rsvd
);
  always_comb begin
    op = OP_OTHER;
    case (ftype)
      4'd2: begin
        if (ttype == 4'd4)       op = OP_NREAD;
        else if (ttype >= 4'd12) op = OP_ATOM2;
      end
      4'd5: begin
        if (ttype == 4'd4)                         op = OP_NWRITE;
        else if (ttype == 4'd5)                    op = OP_NWRITE_R;
        else if (ttype >= 4'd12 && ttype <= 4'd14) op = OP_ATOM5;
      end
      4'd6: op = OP_SWRITE;
      default: op = OP_OTHER;
    endcase
  end

  logic sized_wr;
  assign sized_wr   = (op == OP_NWRITE) || (op == OP_NWRITE_R);
  assign size_bytes = size_to_bytes(size_code, wdptr, sized_wr);
  assign size_rsvd  = (size_bytes == 9'd0);
endmodule

// File: rtl/rv_addr_window.sv
module rv_addr_window #(
  parameter int unsigned NWIN   = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NWIN-1:0]        win_en,
  input  logic [NWIN*ADDR_W-1:0] win_base,
  input  logic [NWIN*ADDR_W-1:0] win_mask,
  output logic                   hit
);
  logic [NWIN-1:0] match;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [ADDR_W-1:0] base_i, mask_i;
    assign base_i   = win_base[i*ADDR_W +: ADDR_W];
    assign mask_i   = win_mask[i*ADDR_W +: ADDR_W];
    assign match[i] = win_en[i] && ((addr & mask_i) == (base_i & mask_i));
  end

  assign hit = |match;
endmodule

// File: rtl/rv_err_capture.sv
module rv_err_capture #(
  parameter int unsigned SRCID_W = 16,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ev_unsup,
  input  logic               ev_ill,
  input  logic [3:0]         in_ftype,
  input  logic [3:0]         in_ttype,
  input  logic [SRCID_W-1:0] in_srcid,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [1:0]         in_prio,
  output logic               unsup_q,
  output logic               ill_q,
  output logic [3:0]         cap_ftype,
  output logic [3:0]         cap_ttype,
  output logic [SRCID_W-1:0] cap_srcid,
  output logic [ADDR_W-1:0]  cap_addr,
  output logic [1:0]         cap_prio
);
  logic held, load;
  assign held = (unsup_q || ill_q) && !clr;
  assign load = (ev_unsup || ev_ill) && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unsup_q <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      unsup_q <= (unsup_q && !clr) || ev_unsup;
      ill_q   <= (ill_q && !clr) || ev_ill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ftype <= '0;
      cap_ttype <= '0;
      cap_srcid <= '0;
      cap_addr  <= '0;
      cap_prio  <= '0;
    end else if (load) begin
      cap_ftype <= in_ftype;
      cap_ttype <= in_ttype;
      cap_srcid <= in_srcid;
      cap_addr  <= in_addr;
      cap_prio  <= in_prio;
    end
  end

  a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (unsup_q && !clr) |=> unsup_q);
  a_r11_sticky_hold_ill: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_q && !clr) |=> ill_q);
  a_r12_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((unsup_q || ill_q) && !clr) |=> ($stable(cap_addr) && $stable(cap_srcid)));
endmodule

// File: rtl/rv_request_checker.sv
module rv_request_checker
  import rv_pkg::*;
#(
  parameter int unsigned NWIN       = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SRCID_W    = 16,
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_valid,
  input  logic [3:0]             hdr_ftype,
  input  logic [3:0]             hdr_ttype,
  input  logic [1:0]             hdr_prio,
  input  logic [3:0]             hdr_size,
  input  logic                   hdr_wdptr,
  input  logic [SRCID_W-1:0]     hdr_srcid,
  input  logic [ADDR_W-1:0]      hdr_addr,
  input  logic [8:0]             hdr_paylen,
  input  logic [5:0]             op_en,
  input  logic [NWIN-1:0]        win_en,
  input  logic [NWIN*ADDR_W-1:0] win_base,
  input  logic [NWIN*ADDR_W-1:0] win_mask,
  input  logic                   err_clr,
  input  logic                   rd_done,
  input  logic                   rd_err,
  output logic                   res_valid,
  output logic [1:0]             res_code,
  output logic                   res_rsp_err,
  output logic                   rd_err_rsp,
  output logic                   err_unsup,
  output logic                   err_illegal,
  output logic [3:0]             cap_ftype,
  output logic [3:0]             cap_ttype,
  output logic [SRCID_W-1:0]     cap_srcid,
  output logic [ADDR_W-1:0]      cap_addr,
  output logic [1:0]             cap_prio
);
  localparam int unsigned BEAT_LSB = $clog2(BEAT_BYTES);

  op_class_e  op;
  logic [8:0] size_bytes;
  logic       size_rsvd;
  logic       win_hit;

  rv_hdr_decode u_dec (
    .ftype      (hdr_ftype),
    .ttype      (hdr_ttype),
    .size_code  (hdr_size),
    .wdptr      (hdr_wdptr),
    .op         (op),
    .size_bytes (size_bytes),
    .size_rsvd  (size_rsvd)
  );

  rv_addr_window #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_win (
    .addr     (hdr_addr),
    .win_en   (win_en),
    .win_base (win_base),
    .win_mask (win_mask),
    .hit      (win_hit)
  );

  // Class groups used by the decode rules
  logic is_rd, is_sized_wr, is_any_wr, is_mem, wants_rsp, supported;
  assign is_rd       = (op == OP_NREAD);
  assign is_sized_wr = (op == OP_NWRITE) || (op == OP_NWRITE_R);
  assign is_any_wr   = is_sized_wr || (op == OP_SWRITE);
  assign is_mem      = is_rd || is_any_wr;
  assign wants_rsp   = is_rd || (op == OP_NWRITE_R) || (op == OP_ATOM5);
  assign supported   = (op != OP_OTHER) && op_en[op[2:0]];

  // Illegal-decode rules, only meaningful for supported classes
  logic bad_prio, bad_presence, bad_rsvd, bad_window, bad_lanes, bad_length;
  assign bad_prio     = (hdr_prio == PRIO_ILLEGAL);
  assign bad_presence = (is_any_wr && hdr_paylen == 9'd0) ||
                        (is_rd && hdr_paylen != 9'd0);
  assign bad_rsvd     = is_sized_wr && size_rsvd;
  assign bad_window   = is_mem && !win_hit;
  assign bad_lanes    = is_rd && (size_bytes[BEAT_LSB-1:0] != '0);
  assign bad_length   = is_sized_wr && !size_rsvd && (hdr_paylen != size_bytes);

  logic     illegal;
  verdict_e verdict;
  assign illegal = supported && (bad_prio || bad_presence || bad_rsvd ||
                                 bad_window || bad_lanes || bad_length);

  always_comb begin
    if (!supported)   verdict = VERDICT_UNSUP;
    else if (illegal) verdict = VERDICT_ILL;
    else              verdict = VERDICT_FWD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_code    <= VERDICT_FWD;
      res_rsp_err <= 1'b0;
      rd_err_rsp  <= 1'b0;
    end else begin
      res_valid   <= hdr_valid;
      res_code    <= hdr_valid ? verdict : VERDICT_FWD;
      res_rsp_err <= hdr_valid && illegal && wants_rsp;
      rd_err_rsp  <= rd_done && rd_err;
    end
  end

  rv_err_capture #(.SRCID_W(SRCID_W), .ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (err_clr),
    .ev_unsup  (hdr_valid && !supported),
    .ev_ill    (hdr_valid && illegal),
    .in_ftype  (hdr_ftype),
    .in_ttype  (hdr_ttype),
    .in_srcid  (hdr_srcid),
    .in_addr   (hdr_addr),
    .in_prio   (hdr_prio),
    .unsup_q   (err_unsup),
    .ill_q     (err_illegal),
    .cap_ftype (cap_ftype),
    .cap_ttype (cap_ttype),
    .cap_srcid (cap_srcid),
    .cap_addr  (cap_addr),
    .cap_prio  (cap_prio)
  );

  a_r1_verdict_timing: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> res_valid);
  a_r1_no_spurious_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !res_valid);
  a_r9_rsp_only_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    res_rsp_err |-> (res_valid && res_code == VERDICT_ILL));
  a_r11_illegal_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == VERDICT_ILL) |-> err_illegal);
  a_r11_unsup_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == VERDICT_UNSUP) |-> err_unsup);
  a_r10_read_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> !rd_err_rsp);
endmodule

// File: tb/test_rv_request_checker.sv
module test_rv_request_checker;
  localparam int NWIN = 4, ADDR_W = 32, SRCID_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                   hdr_valid = 1'b0;
  logic [3:0]             hdr_ftype = '0, hdr_ttype = '0, hdr_size = '0;
  logic [1:0]             hdr_prio = '0;
  logic                   hdr_wdptr = 1'b0;
  logic [SRCID_W-1:0]     hdr_srcid = '0;
  logic [ADDR_W-1:0]      hdr_addr = '0;
  logic [8:0]             hdr_paylen = '0;
  logic [5:0]             op_en = 6'b10_1111;
  logic [NWIN-1:0]        win_en = 4'b0011;
  logic [NWIN*ADDR_W-1:0] win_base = {32'h4000_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000};
  logic [NWIN*ADDR_W-1:0] win_mask = {32'hFF00_0000, 32'hFF00_0000, 32'hFF00_0000, 32'hFFFF_0000};
  logic                   err_clr = 1'b0, rd_done = 1'b0, rd_err = 1'b0;
  logic                   res_valid, res_rsp_err, rd_err_rsp, err_unsup, err_illegal;
  logic [1:0]             res_code, cap_prio;
  logic [3:0]             cap_ftype, cap_ttype;
  logic [SRCID_W-1:0]     cap_srcid;
  logic [ADDR_W-1:0]      cap_addr;

  rv_request_checker #(.NWIN(NWIN), .ADDR_W(ADDR_W), .SRCID_W(SRCID_W)) i_rv_request_checker (
    .clk, .rst_n, .hdr_valid, .hdr_ftype, .hdr_ttype, .hdr_prio, .hdr_size,
    .hdr_wdptr, .hdr_srcid, .hdr_addr, .hdr_paylen, .op_en, .win_en, .win_base,
    .win_mask, .err_clr, .rd_done, .rd_err, .res_valid, .res_code, .res_rsp_err,
    .rd_err_rsp, .err_unsup, .err_illegal, .cap_ftype, .cap_ttype, .cap_srcid,
    .cap_addr, .cap_prio);

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [1:0] V_FWD = 2'd0, V_UNS = 2'd1, V_ILL = 2'd2;
  localparam logic [31:0] A_OK = 32'h1000_0040, A_OK2 = 32'h2055_0000, A_OFF = 32'h3000_0000;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one header for a cycle; on return the verdict is on the outputs.
  task automatic send(input logic [3:0] ft, input logic [3:0] tt, input logic [1:0] pr,
                      input logic [3:0] sz, input logic wp, input logic [31:0] ad,
                      input logic [8:0] pl, input logic [15:0] sid);
    @(negedge clk);
    hdr_ftype = ft; hdr_ttype = tt; hdr_prio = pr; hdr_size = sz;
    hdr_wdptr = wp; hdr_addr = ad; hdr_paylen = pl; hdr_srcid = sid;
    hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic expect_v(input string req, input logic [1:0] code, input logic rsp);
    chk(req, "res_valid", res_valid, 1);
    chk(req, "res_code", res_code, code);
    chk(req, "res_rsp_err", res_rsp_err, rsp);
  endtask

  task automatic clear_errors();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "res_valid at reset", res_valid, 0);
    chk("R11", "sticky at reset", {err_unsup, err_illegal}, 0);
    chk("R12", "cap_addr at reset", cap_addr, 0);
  endtask

  task automatic t_legal();
    send(4'd2, 4'd4, 2'd0, 4'd11, 1'b0, A_OK, 9'd0, 16'h1);
    expect_v("R1", V_FWD, 0);
    send(4'd2, 4'd4, 2'd2, 4'd13, 1'b0, A_OK2, 9'd0, 16'h1);  // 96 bytes read
    expect_v("R7", V_FWD, 0);
    send(4'd5, 4'd4, 2'd1, 4'd12, 1'b1, A_OK, 9'd64, 16'h2);
    expect_v("R8", V_FWD, 0);
    send(4'd5, 4'd5, 2'd0, 4'd11, 1'b1, A_OK, 9'd16, 16'h3);
    expect_v("R8", V_FWD, 0);
    send(4'd6, 4'd0, 2'd0, 4'd0, 1'b0, A_OK2, 9'd32, 16'h4);
    expect_v("R6", V_FWD, 0);
    send(4'd5, 4'd13, 2'd0, 4'd0, 1'b0, A_OFF, 9'd8, 16'h5);  // atomic-5, no window rule
    expect_v("R2", V_FWD, 0);
    @(negedge clk);
    chk("R1", "res_valid idle", res_valid, 0);
    chk("R11", "no sticky after legal", {err_unsup, err_illegal}, 0);
  endtask

  task automatic t_unsup_capture();
    send(4'd2, 4'd12, 2'd1, 4'd0, 1'b0, 32'h1000_0100, 9'd0, 16'hA1);  // atomic-2 disabled
    expect_v("R2", V_UNS, 0);
    chk("R11", "err_unsup set", err_unsup, 1);
    chk("R12", "cap_srcid first", cap_srcid, 16'hA1);
    chk("R12", "cap_ftype first", {cap_ftype, cap_ttype, cap_prio}, {4'd2, 4'd12, 2'd1});
    send(4'd8, 4'd0, 2'd0, 4'd0, 1'b0, 32'h1000_0200, 9'd0, 16'hA2);   // reserved ftype
    expect_v("R2", V_UNS, 0);
    send(4'd2, 4'd4, 2'd3, 4'd11, 1'b0, A_OK, 9'd0, 16'hA3);            // priority 3 read
    expect_v("R3", V_ILL, 1);
    chk("R11", "err_illegal set", err_illegal, 1);
    chk("R12", "cap_addr held", cap_addr, 32'h1000_0100);
    chk("R12", "cap_srcid held", cap_srcid, 16'hA1);
    send(4'd5, 4'd4, 2'd0, 4'd12, 1'b1, A_OK, 9'd64, 16'h7);
    chk("R11", "sticky survives legal", {err_unsup, err_illegal}, 2'b11);
    clear_errors();
    chk("R11", "cleared", {err_unsup, err_illegal}, 0);
  endtask

  task automatic t_illegal_rules();
    send(4'd5, 4'd4, 2'd0, 4'd11, 1'b0, A_OK, 9'd0, 16'hB1);   // write without payload
    expect_v("R4", V_ILL, 0);
    chk("R12", "load after clear", cap_srcid, 16'hB1);
    send(4'd6, 4'd0, 2'd0, 4'd0, 1'b0, A_OK, 9'd0, 16'hB2);    // stream write without payload
    expect_v("R4", V_ILL, 0);
    send(4'd2, 4'd4, 2'd0, 4'd11, 1'b0, A_OK, 9'd8, 16'hB3);   // read with payload
    expect_v("R4", V_ILL, 1);
    send(4'd5, 4'd5, 2'd0, 4'd14, 1'b1, A_OK, 9'd192, 16'hB4); // reserved 14/1
    expect_v("R5", V_ILL, 1);
    send(4'd5, 4'd4, 2'd0, 4'd15, 1'b0, A_OK, 9'd224, 16'hB5); // reserved 15/0
    expect_v("R5", V_ILL, 0);
    send(4'd5, 4'd5, 2'd0, 4'd11, 1'b0, A_OFF, 9'd8, 16'hB6);  // disabled window
    expect_v("R6", V_ILL, 1);
    send(4'd6, 4'd0, 2'd0, 4'd0, 1'b0, 32'h1001_0000, 9'd8, 16'hB7); // just outside win0
    expect_v("R6", V_ILL, 0);
    send(4'd2, 4'd4, 2'd0, 4'd8, 1'b1, A_OK, 9'd0, 16'hB8);    // 4-byte read
    expect_v("R7", V_ILL, 1);
    send(4'd5, 4'd4, 2'd0, 4'd12, 1'b0, A_OK, 9'd16, 16'hB9);  // 32 implied, 16 sent
    expect_v("R8", V_ILL, 0);
    send(4'd5, 4'd5, 2'd0, 4'd9, 1'b0, A_OK, 9'd6, 16'hBA);    // 6-byte write, lengths agree
    expect_v("R8", V_FWD, 0);
    send(4'd5, 4'd12, 2'd3, 4'd0, 1'b0, A_OK, 9'd8, 16'hBB);   // atomic-5 prio 3
    expect_v("R9", V_ILL, 1);
    chk("R12", "first illegal kept", cap_srcid, 16'hB1);
  endtask

  task automatic t_priority_order();
    clear_errors();
    op_en = 6'b10_1110;                                         // disable read class
    send(4'd2, 4'd4, 2'd3, 4'd8, 1'b0, A_OFF, 9'd4, 16'hC1);
    expect_v("R2", V_UNS, 0);
    chk("R2", "illegal not flagged", err_illegal, 0);
    op_en = 6'b10_1111;
    // error coincident with clear still sets and captures
    @(negedge clk);
    err_clr = 1'b1;
    hdr_ftype = 4'd2; hdr_ttype = 4'd4; hdr_prio = 2'd3; hdr_size = 4'd11;
    hdr_wdptr = 1'b0; hdr_addr = A_OK; hdr_paylen = 9'd0; hdr_srcid = 16'hC2;
    hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0; err_clr = 1'b0;
    chk("R11", "error wins over clear", {err_unsup, err_illegal}, 2'b01);
    chk("R12", "capture on clear cycle", cap_srcid, 16'hC2);
  endtask

  task automatic t_read_error();
    @(negedge clk); rd_done = 1'b1; rd_err = 1'b1;
    @(negedge clk); rd_done = 1'b0; rd_err = 1'b0;
    chk("R10", "rd_err_rsp on error", rd_err_rsp, 1);
    @(negedge clk);
    chk("R10", "rd_err_rsp drops", rd_err_rsp, 0);
    rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0;
    chk("R10", "clean final beat", rd_err_rsp, 0);
    rd_err = 1'b1;
    @(negedge clk); rd_err = 1'b0;
    chk("R10", "error without final beat", rd_err_rsp, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_legal();
    t_unsup_capture();
    t_illegal_rules();
    t_priority_order();
    t_read_error();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule